// File: doc/BRIEF.md
# Line-Start Bus Takeover Controller

This block takes the shared screen-memory bus away from a processor for every active video line. When the video timing chain marks the start of a line, the controller raises a bus request. A short bridge timer keeps the request up until the line interval level arrives, and the request then stays up for as long as that level is high. A fixed hold-off after the request rises, the controller turns on its own address and data buffers. It does not wait for any grant, because the line has to start at a fixed time. When the line ends it drops the buffers and the request together.

A video-enable input gates the whole mechanism. With video off, no request is raised and the buffers stay off. The processor may run from a clock unrelated to this block's clock. Its bus-release acknowledge therefore passes through a synchronizer and is offered only as a status level. It never gates the takeover. The hold-off is counted in controller clock cycles. It is derived from the clock frequency and a hold-off time in nanoseconds, and comes to 60 cycles at 4 MHz and 15000 ns. Every control and status pin is a plain level or pulse. No data stream passes through this block, so it has no valid/ready handshake.

Top module: `line_bus_seize`

## Requirements
- R1: During and straight after reset, bus_req, buf_en and ack_sync are all 0.
- R2: A cycle with line_start=1 and video_on=1 makes bus_req 1 from the next clock edge on.
- R3: Once raised, bus_req stays 1 with no gap for at least BRIDGE+1 cycles (BRIDGE defaults to 4), and for every cycle in which line_hold was 1 on the previous edge, while video_on stays 1.
- R4: bus_req falls on the first edge at which line_hold is 0 and the bridge time has expired. For a line with line_hold high for L edges after the start, bus_req is 1 for max(L, BRIDGE+1) cycles.
- R5: buf_en rises exactly DELAY cycles after bus_req rises (DELAY = 60 at default parameters), whatever the level of cpu_ack.
- R6: buf_en falls on the same edge as bus_req, and buf_en is never 1 while bus_req is 0.
- R7: With video_on=0, line_start is ignored and both outputs stay 0. video_on falling mid-line clears both outputs on the next edge.
- R8: ack_sync follows cpu_ack two clock edges later, and cpu_ack has no effect on bus_req or buf_en.
- R9: A line whose request lasts DELAY cycles or fewer never raises buf_en.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset |
| video_on | input | 1 | Enables the takeover mechanism |
| line_start | input | 1 | One-cycle pulse at the start of a video line |
| line_hold | input | 1 | High for the active interval of the line |
| cpu_ack | input | 1 | Processor bus-release acknowledge, asynchronous |
| bus_req | output | 1 | Bus request level to the processor |
| buf_en | output | 1 | Enable for the address and data buffers |
| ack_sync | output | 1 | Synchronized acknowledge, status only |

## Verification
A table of lines is run through the block. Each line has its own length, video-enable level and acknowledge level. Long lines confirm the exact hold-off and the joint release at line end. Lines of DELAY and DELAY+1 cycles separate "never enabled" from "enabled for one cycle". A two-cycle line shows that the bridge timer, and not line_hold, holds the request. Lines run with video off and with the acknowledge held high show that neither the enable nor the acknowledge changes anything except what their requirements name. Directed tests cover the reset state, the synchronizer latency and video switched off in the middle of a line.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
  // Hold-off length in controller cycles, from clock rate and time in ns.
  function automatic int unsigned holdoff_cycles(input int unsigned clk_hz,
                                                 input int unsigned hold_ns);
    int unsigned c;
    c = ((clk_hz / 1000) * hold_ns) / 1000000;
    if (c < 2) c = 2;
    return c;
  endfunction
endpackage

// File: rtl/lbs_ack_sync.sv
module lbs_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/lbs_req_gen.sv
module lbs_req_gen #(
  parameter int BRIDGE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic video_on,
  input  logic line_start,
  input  logic line_hold,
  output logic req_q,
  output logic req_d
);
  localparam int BW = $clog2(BRIDGE + 1);
  localparam logic [BW-1:0] BRIDGE_LD = BW'(BRIDGE);

  logic [BW-1:0] bridge_q;
  logic          bridge_busy;

  assign bridge_busy = (bridge_q != '0);
  // Registered request: the start pulse sets it, bridge or hold keeps it.
  assign req_d = video_on & (line_start | (req_q & (bridge_busy | line_hold)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bridge_q <= '0;
      req_q    <= 1'b0;
    end else begin
      req_q <= req_d;
      if (line_start && video_on) bridge_q <= BRIDGE_LD;
      else if (bridge_busy)       bridge_q <= bridge_q - 1'b1;
    end
  end
endmodule

// File: rtl/lbs_holdoff.sv
module lbs_holdoff #(
  parameter int DELAY = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_q,
  input  logic req_d,
  output logic en_q
);
  localparam int CW = (DELAY < 2) ? 1 : $clog2(DELAY);
  localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

  logic [CW-1:0] cnt_q;
  logic          expire;
  logic          en_d;

  assign expire = req_q & (cnt_q == LAST);
  // Enable only while the request survives this edge; drops with it.
  assign en_d   = req_d & (en_q | expire);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else begin
      en_q <= en_d;
      if (!req_q)            cnt_q <= '0;
      else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/line_bus_seize.sv
module line_bus_seize #(
  parameter int CLK_HZ      = 4000000,
  parameter int HOLDOFF_NS  = 15000,
  parameter int BRIDGE      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic video_on,
  input  logic line_start,
  input  logic line_hold,
  input  logic cpu_ack,
  output logic bus_req,
  output logic buf_en,
  output logic ack_sync
);
  localparam int DELAY = int'(lbs_pkg::holdoff_cycles(CLK_HZ, HOLDOFF_NS));

  logic req_q;
  logic req_d;

  lbs_req_gen #(.BRIDGE(BRIDGE)) u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .video_on  (video_on),
    .line_start(line_start),
    .line_hold (line_hold),
    .req_q     (req_q),
    .req_d     (req_d)
  );

  lbs_holdoff #(.DELAY(DELAY)) u_hold (
    .clk  (clk),
    .rst_n(rst_n),
    .req_q(req_q),
    .req_d(req_d),
    .en_q (buf_en)
  );

  lbs_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in(cpu_ack),
    .sync_out(ack_sync)
  );

  assign bus_req = req_q;
endmodule

// File: rtl/line_bus_seize_chk.sv
module line_bus_seize_chk #(
  parameter int DELAY       = 60,
  parameter int SYNC_STAGES = 2
) (
  input logic clk,
  input logic rst_n,
  input logic video_on,
  input logic line_start,
  input logic line_hold,
  input logic cpu_ack,
  input logic bus_req,
  input logic buf_en,
  input logic ack_sync
);
  logic [15:0] run_q;
  logic [1:0]  since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= '0;
      since_rst <= '0;
    end else begin
      if (!bus_req)            run_q <= '0;
      else if (run_q != '1)    run_q <= run_q + 1'b1;
      if (since_rst != 2'd3)   since_rst <= since_rst + 1'b1;
    end
  end

  p_start_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && video_on) |=> bus_req);

  p_no_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && line_hold && video_on) |=> bus_req);

  p_holdoff_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_en) |-> (run_q == 16'(DELAY)));

  p_en_in_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    buf_en |-> bus_req);

  p_joint_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_en && $fell(bus_req)) |-> 1'b0);

  p_video_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !video_on |=> (!bus_req && !buf_en));

  generate
    if (SYNC_STAGES == 2) begin : g_sync_chk
      p_ack_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> (ack_sync == $past(cpu_ack, 2)));
    end
  endgenerate
endmodule

bind line_bus_seize line_bus_seize_chk #(.DELAY(DELAY), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .video_on  (video_on),
  .line_start(line_start),
  .line_hold (line_hold),
  .cpu_ack   (cpu_ack),
  .bus_req   (bus_req),
  .buf_en    (buf_en),
  .ack_sync  (ack_sync)
);

// File: tb/sim_line_bus_seize.sv
`timescale 1ns/1ps
module sim_line_bus_seize;
  localparam int DELAY  = 60;
  localparam int BRIDGE = 4;
  localparam int NROWS  = 7;

  typedef struct packed {
    logic [15:0] len;
    logic        von;
    logic        ack;
  } row_t;

  // len = edges with line_hold high, von = video enable, ack = cpu_ack level
  localparam row_t ROWS [NROWS] = '{
    '{16'd100, 1'b1, 1'b0},  // R2 R4 R5 R6 long line
    '{16'd61,  1'b1, 1'b0},  // R5 R9 boundary: one enabled cycle
    '{16'd60,  1'b1, 1'b0},  // R9 exactly DELAY: never enabled
    '{16'd59,  1'b1, 1'b0},  // R9 short line
    '{16'd2,   1'b1, 1'b0},  // R3 bridge holds request
    '{16'd100, 1'b0, 1'b0},  // R7 video off
    '{16'd100, 1'b1, 1'b1}   // R8 ack held high has no effect
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic video_on = 1'b0, line_start = 1'b0, line_hold = 1'b0, cpu_ack = 1'b0;
  logic bus_req, buf_en, ack_sync;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  line_bus_seize u0 (
    .clk(clk), .rst_n(rst_n), .video_on(video_on), .line_start(line_start),
    .line_hold(line_hold), .cpu_ack(cpu_ack),
    .bus_req(bus_req), .buf_en(buf_en), .ack_sync(ack_sync)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    line_start = 1'b0; line_hold = 1'b0;
    for (int i = 0; i < n; i++) step();
  endtask

  // Runs one line and compares every cycle against the requirement model.
  task automatic run_row(input row_t r, input string tag);
    int lim, bad_r, bad_b;
    logic er, eb, ar, ab;
    lim = (int'(r.len) > BRIDGE + 1) ? int'(r.len) : BRIDGE + 1;
    bad_r = 0; bad_b = 0; ar = 1'b0; er = 1'b0; ab = 1'b0; eb = 1'b0;
    video_on = r.von; cpu_ack = r.ack;
    line_start = 1'b1; line_hold = 1'b1;
    for (int k = 1; k <= int'(r.len) + 10; k++) begin
      step();
      er = r.von && (k <= lim);
      eb = er && (k >= DELAY + 1);
      if (bus_req !== er && bad_r == 0) begin bad_r = k; ar = bus_req; end
      if (buf_en !== eb && bad_b == 0)  begin bad_b = k; ab = buf_en; end
      line_start = 1'b0;
      if (k >= int'(r.len)) line_hold = 1'b0;
    end
    checks += 2;
    if (bad_r != 0) begin
      errors++;
      $display("FAIL %s bus_req len=%0d cycle=%0d actual=%0b expected=%0b",
               tag, r.len, bad_r, ar, !ar);
    end
    if (bad_b != 0) begin
      errors++;
      $display("FAIL %s buf_en len=%0d cycle=%0d actual=%0b expected=%0b",
               tag, r.len, bad_b, ab, !ab);
    end
    cpu_ack = 1'b0;
    idle(8);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    string tag;
    // R1: reset state, with inputs active during reset
    video_on = 1'b1; line_start = 1'b1; line_hold = 1'b1; cpu_ack = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check("R1 bus_req in reset", bus_req, 1'b0);
    check("R1 buf_en in reset", buf_en, 1'b0);
    check("R1 ack_sync in reset", ack_sync, 1'b0);
    line_start = 1'b0; line_hold = 1'b0; cpu_ack = 1'b0; video_on = 1'b0;
    rst_n = 1'b1;
    step();
    check("R1 bus_req after reset", bus_req, 1'b0);
    check("R1 buf_en after reset", buf_en, 1'b0);
    idle(4);

    for (int i = 0; i < NROWS; i++) begin
      if (!ROWS[i].von)                          tag = "R7";
      else if (ROWS[i].ack)                      tag = "R8";
      else if (int'(ROWS[i].len) <= BRIDGE)      tag = "R3";
      else if (int'(ROWS[i].len) <= DELAY + 1)   tag = "R9";
      else                                       tag = "R5";
      run_row(ROWS[i], tag);
    end

    // R8: synchronizer latency of two edges
    cpu_ack = 1'b1;
    step();
    check("R8 ack_sync after 1 edge", ack_sync, 1'b0);
    step();
    check("R8 ack_sync after 2 edges", ack_sync, 1'b1);
    cpu_ack = 1'b0;
    step(); step();
    check("R8 ack_sync falls", ack_sync, 1'b0);

    // R7: video off mid-line clears both outputs on the next edge
    video_on = 1'b1; line_start = 1'b1; line_hold = 1'b1;
    for (int k = 1; k <= 70; k++) begin
      step();
      line_start = 1'b0;
    end
    check("R5 buf_en on mid-line", buf_en, 1'b1);
    video_on = 1'b0;
    step();
    check("R7 bus_req after video off", bus_req, 1'b0);
    check("R7 buf_en after video off", buf_en, 1'b0);
    // R7: line_start ignored with video off
    line_start = 1'b1;
    step();
    line_start = 1'b0;
    check("R7 start ignored", bus_req, 1'b0);
    idle(4);

    // R4: request falls one edge after hold ends (bridge long expired)
    video_on = 1'b1; line_start = 1'b1; line_hold = 1'b1;
    for (int k = 1; k <= 20; k++) begin
      step();
      line_start = 1'b0;
    end
    line_hold = 1'b0;
    check("R4 bus_req before end edge", bus_req, 1'b1);
    step();
    check("R4 bus_req after end edge", bus_req, 1'b0);
    check("R6 buf_en after end edge", buf_en, 1'b0);
    idle(4);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule